// File: doc/BRIEF.md
# Command List Walker

This block is the command-side sequencer of a LAN coprocessor. The host writes a chain of command blocks into shared memory, places the address of the first block on `list_head`, and pulses `ca`, the channel-attention strobe. On that strobe the unit samples a host command and two acknowledge bits. The host command can start the list, resume it, suspend it, or abort it. While the unit is active it fetches each block's command word and its link word through a single-request memory port. It then hands the block to a stub executor with a fixed latency and writes the completion status back into the command word. After that it follows the link, or it stops as the block's flags direct.

Each block occupies two consecutive words. Word 0 is the command/status word. Word 1 is the link, and its low `AW` bits give the address of the next block. In the command word, bit 31 ends the list, bit 30 asks for a suspend once the block completes, bit 29 asks for an interrupt, and bits 18:16 carry an opcode that the stub does not decode. On write-back, bits 31:16 are kept as read and bits 15:0 are replaced by the status: bit 15 complete, bit 14 busy (always 0 when written), bit 13 OK, bit 12 aborted.

The unit state, visible on `cu_state`, is IDLE (0), SUSPENDED (1) or ACTIVE (2). Inside ACTIVE a walker steps through the phases FETCH_CMD, WAIT_CMD, FETCH_LINK, WAIT_LINK, EXECUTE, WRITE_STATUS and WAIT_STATUS. The named transitions are:
- START: IDLE or SUSPENDED to ACTIVE at `list_head`.
- RESUME: SUSPENDED to ACTIVE at the saved link.
- NEXT: WAIT_STATUS back to FETCH_CMD.
- FINISH: ACTIVE to IDLE on end of list.
- PARK: ACTIVE to SUSPENDED.
- KILL: an abort, ACTIVE or SUSPENDED to IDLE.
- CLEAR: a soft reset, any state to IDLE.

Top module: `cmd_list_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `cu_state` is 0 (IDLE), `mem_req` is 0 and `flag_cx`, `flag_cna` and `irq` are all 0.
- R2: A strobe with host command 1 (start) in IDLE or SUSPENDED sets `cu_state` to 2 (ACTIVE). The first command word is read at `list_head` and its link word at `list_head`+1, and memory is only requested while ACTIVE.
- R3: After the link read, the block runs for `EXEC_CYCLES` cycles. Its command word is then written back with bits 31:16 unchanged and bits 15:0 = 0xA000 (complete and OK). If neither bit 31 nor bit 30 is set, the next block is fetched at the link address.
- R4: When a block with bit 31 set completes, the unit goes to IDLE and `flag_cna` is set. Any exit from ACTIVE other than a soft reset sets `flag_cna`.
- R5: When a block with bit 30 set completes, or any block completes after host command 3 (suspend) was taken while ACTIVE, the unit goes to SUSPENDED (1). Later blocks stay untouched. Host command 2 (resume) in SUSPENDED then continues at the suspended block's link address.
- R6: `flag_cx` is set when a block with bit 29 set completes normally. An aborted block does not set it.
- R7: Host command 4 (abort) while ACTIVE writes the current block back with bits 15:0 = 0x9000 (complete and aborted, not OK), moves to IDLE and sets `flag_cna`. In SUSPENDED it moves to IDLE without any memory write.
- R8: Host command 1 while ACTIVE is ignored. The walk continues down the current list, and the block at the new `list_head` is not read.
- R9: A strobe with `host_ack_cx` clears `flag_cx` and one with `host_ack_cna` clears `flag_cna`. If the same flag is set in that same cycle, the set wins.
- R10: `irq` is a register that equals the OR of `flag_cx` and `flag_cna` one cycle earlier.
- R11: A strobe with `host_reset` high forces IDLE and clears both flags on the next edge, whatever the host command is. No status is written for the interrupted block.
- R12: Host commands 0, 5, 6 and 7 change neither the unit state nor the flags, whether IDLE or ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ca | input | 1 | Channel-attention strobe, one cycle per host request |
| host_cmd | input | 3 | Host command sampled on `ca` |
| host_ack_cx | input | 1 | Acknowledge for the command-executed flag |
| host_ack_cna | input | 1 | Acknowledge for the not-active flag |
| host_reset | input | 1 | Soft reset sampled on `ca` |
| list_head | input | AW | Address of the first block, used by start |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | 32 | Write data (command word with status) |
| mem_rvalid | input | 1 | Response strobe for both reads and writes |
| mem_rdata | input | 32 | Read data, valid with `mem_rvalid` |
| cu_state | output | 2 | Unit state: 0 IDLE, 1 SUSPENDED, 2 ACTIVE |
| flag_cx | output | 1 | Command-executed flag |
| flag_cna | output | 1 | Not-active flag |
| irq | output | 1 | Registered OR of the flags |

## Verification
Two events can land on the same clock edge: a host acknowledge, and the completion of a block that sets the flag being acknowledged. The bench provokes this by watching the port for the status-write request. It then raises the strobe with both acknowledge bits exactly on the cycle that the write response returns. The design must keep both flags set afterwards. A second overlap, a start strobe arriving while a list is being walked, is judged by the order of the command-word reads and by the untouched block at the new head address.

// File: rtl/cmdu_pkg.sv
package cmdu_pkg;

    typedef enum logic [1:0] {
        CU_IDLE   = 2'd0,
        CU_SUSP   = 2'd1,
        CU_ACTIVE = 2'd2
    } cu_state_e;

    typedef enum logic [2:0] {
        HC_NOP      = 3'd0,
        HC_START    = 3'd1,
        HC_RESUME   = 3'd2,
        HC_SUSPEND  = 3'd3,
        HC_ABORT    = 3'd4,
        HC_THR_NEXT = 3'd5,
        HC_THR_NOW  = 3'd6,
        HC_SPARE    = 3'd7
    } host_cmd_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_RD_CMD,
        W_WT_CMD,
        W_RD_LNK,
        W_WT_LNK,
        W_EXEC,
        W_WR_ST,
        W_WT_ST
    } walk_e;

    // flag positions inside the command word
    localparam int EL_BIT   = 31;
    localparam int SUSP_BIT = 30;
    localparam int INT_BIT  = 29;

    // status half written back into bits 15:0
    localparam logic [15:0] ST_NORMAL = 16'hA000;
    localparam logic [15:0] ST_ABORT  = 16'h9000;

endpackage

// File: rtl/cmdu_stub.sv
module cmdu_stub #(
    parameter int EXEC_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(EXEC_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == CW'(EXEC_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/cmdu_flags.sv
module cmdu_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic clr_cx,
    input  logic clr_cna,
    input  logic set_cx,
    input  logic set_cna,
    output logic cx,
    output logic cna,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cx  <= 1'b0;
            cna <= 1'b0;
            irq <= 1'b0;
        end else begin
            irq <= cx | cna;
            if (soft_rst) begin
                cx  <= 1'b0;
                cna <= 1'b0;
            end else begin
                cx  <= set_cx  | (cx  & ~clr_cx);
                cna <= set_cna | (cna & ~clr_cna);
            end
        end
    end
endmodule

// File: rtl/cmdu_walker.sv
module cmdu_walker
    import cmdu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          cmd_valid,
    input  host_cmd_e     cmd,
    input  logic [AW-1:0] list_head,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          exec_run,
    input  logic          exec_done,
    output cu_state_e     cu_state,
    output logic          set_cx,
    output logic          set_cna
);
    walk_e         walk_q, walk_d;
    cu_state_e     cu_q, cu_d;
    logic [AW-1:0] ptr_q, ptr_d, link_q, link_d;
    logic [15:0]   hi_q, hi_d, st_q, st_d;
    logic          susp_q, susp_d, abrt_q, abrt_d;
    logic          unused_rd_bits;

    assign unused_rd_bits = ^mem_rdata;

    // next-state process
    always_comb begin
        walk_d  = walk_q;
        cu_d    = cu_q;
        ptr_d   = ptr_q;
        link_d  = link_q;
        hi_d    = hi_q;
        st_d    = st_q;
        susp_d  = susp_q;
        abrt_d  = abrt_q;
        set_cx  = 1'b0;
        set_cna = 1'b0;

        unique case (walk_q)
            W_IDLE:   ;
            W_RD_CMD: walk_d = W_WT_CMD;
            W_WT_CMD: if (mem_rvalid) begin
                hi_d = mem_rdata[31:16];
                if (abrt_q) begin
                    st_d   = ST_ABORT;
                    walk_d = W_WR_ST;
                end else begin
                    walk_d = W_RD_LNK;
                end
            end
            W_RD_LNK: walk_d = W_WT_LNK;
            W_WT_LNK: if (mem_rvalid) begin
                link_d = mem_rdata[AW-1:0];
                if (abrt_q) begin
                    st_d   = ST_ABORT;
                    walk_d = W_WR_ST;
                end else begin
                    walk_d = W_EXEC;
                end
            end
            W_EXEC: if (abrt_q || exec_done) begin
                st_d   = abrt_q ? ST_ABORT : ST_NORMAL;
                walk_d = W_WR_ST;
            end
            W_WR_ST:  walk_d = W_WT_ST;
            W_WT_ST: if (mem_rvalid) begin
                set_cx = (st_q == ST_NORMAL) && hi_q[INT_BIT-16];
                if (abrt_q || hi_q[EL_BIT-16]) begin
                    walk_d  = W_IDLE;          // FINISH / KILL
                    cu_d    = CU_IDLE;
                    set_cna = 1'b1;
                end else if (hi_q[SUSP_BIT-16] || susp_q) begin
                    walk_d  = W_IDLE;          // PARK
                    cu_d    = CU_SUSP;
                    set_cna = 1'b1;
                end else begin
                    ptr_d  = link_q;           // NEXT
                    walk_d = W_RD_CMD;
                end
            end
            default: walk_d = W_IDLE;
        endcase

        if (cmd_valid) begin
            unique case (cmd)
                HC_START: if (cu_q != CU_ACTIVE) begin
                    cu_d   = CU_ACTIVE;
                    walk_d = W_RD_CMD;
                    ptr_d  = list_head;
                    susp_d = 1'b0;
                    abrt_d = 1'b0;
                end
                HC_RESUME: if (cu_q == CU_SUSP) begin
                    cu_d   = CU_ACTIVE;
                    walk_d = W_RD_CMD;
                    ptr_d  = link_q;
                    susp_d = 1'b0;
                    abrt_d = 1'b0;
                end
                HC_SUSPEND: if (cu_q == CU_ACTIVE) susp_d = 1'b1;
                HC_ABORT: begin
                    if (cu_q == CU_ACTIVE)    abrt_d = 1'b1;
                    else if (cu_q == CU_SUSP) cu_d   = CU_IDLE;
                end
                default: ;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            walk_q <= W_IDLE;
            cu_q   <= CU_IDLE;
            ptr_q  <= '0;
            link_q <= '0;
            hi_q   <= '0;
            st_q   <= '0;
            susp_q <= 1'b0;
            abrt_q <= 1'b0;
        end else begin
            walk_q <= walk_d;
            cu_q   <= cu_d;
            ptr_q  <= ptr_d;
            link_q <= link_d;
            hi_q   <= hi_d;
            st_q   <= st_d;
            susp_q <= susp_d;
            abrt_q <= abrt_d;
        end
    end

    // output process
    always_comb begin
        mem_req   = (walk_q == W_RD_CMD) || (walk_q == W_RD_LNK) || (walk_q == W_WR_ST);
        mem_we    = (walk_q == W_WR_ST);
        mem_addr  = (walk_q == W_RD_LNK) ? ptr_q + AW'(1) : ptr_q;
        mem_wdata = {hi_q, st_q};
        exec_run  = (walk_q == W_EXEC);
        cu_state  = cu_q;
    end
endmodule

// File: rtl/cmd_list_unit.sv
module cmd_list_unit
    import cmdu_pkg::*;
#(
    parameter int AW          = 16,
    parameter int EXEC_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ca,
    input  logic [2:0]    host_cmd,
    input  logic          host_ack_cx,
    input  logic          host_ack_cna,
    input  logic          host_reset,
    input  logic [AW-1:0] list_head,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic [1:0]    cu_state,
    output logic          flag_cx,
    output logic          flag_cna,
    output logic          irq
);
    logic      soft_rst, cmd_valid;
    logic      exec_run, exec_done;
    logic      set_cx, set_cna;
    cu_state_e cu_st;

    assign soft_rst  = ca & host_reset;
    assign cmd_valid = ca & ~host_reset;
    assign cu_state  = cu_st;

    cmdu_walker #(.AW(AW)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .cmd_valid  (cmd_valid),
        .cmd        (host_cmd_e'(host_cmd)),
        .list_head  (list_head),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .exec_run   (exec_run),
        .exec_done  (exec_done),
        .cu_state   (cu_st),
        .set_cx     (set_cx),
        .set_cna    (set_cna)
    );

    cmdu_stub #(.EXEC_CYCLES(EXEC_CYCLES)) u_stub (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (exec_run),
        .done  (exec_done)
    );

    cmdu_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .clr_cx   (ca & host_ack_cx),
        .clr_cna  (ca & host_ack_cna),
        .set_cx   (set_cx),
        .set_cna  (set_cna),
        .cx       (flag_cx),
        .cna      (flag_cna),
        .irq      (irq)
    );
endmodule

// File: rtl/cmd_list_unit_chk.sv
module cmd_list_unit_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ca,
    input logic [2:0]    host_cmd,
    input logic          host_ack_cx,
    input logic          host_ack_cna,
    input logic          host_reset,
    input logic [AW-1:0] list_head,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_rvalid,
    input logic [31:0]   mem_rdata,
    input logic [1:0]    cu_state,
    input logic          flag_cx,
    input logic          flag_cna,
    input logic          irq
);
    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (cu_state == 2'd0 && !mem_req && !irq && !flag_cx && !flag_cna));

    // R2
    a_r2_req_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (cu_state == 2'd2));

    // R3 and R7
    a_r3_writeback_format: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[15] && !mem_wdata[14]
                                 && (mem_wdata[13] != mem_wdata[12])
                                 && mem_wdata[11:0] == 12'h000));

    // R4
    a_r4_cna_on_leave: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cu_state) == 2'd2 && cu_state != 2'd2 && !$past(ca && host_reset))
        |-> flag_cna);

    // R10
    a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(flag_cx | flag_cna));

    // R11
    a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (ca && host_reset) |=> (cu_state == 2'd0 && !flag_cx && !flag_cna));

    logic unused_chk;
    assign unused_chk = ^{host_cmd, host_ack_cx, host_ack_cna, list_head,
                          mem_addr, mem_rvalid, mem_rdata};
endmodule

bind cmd_list_unit cmd_list_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/cmd_list_unit_bench.sv
module cmd_list_unit_bench;
    localparam int AW = 16;
    localparam int EXC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ca = 1'b0;
    logic [2:0]    host_cmd = 3'd0;
    logic          host_ack_cx = 1'b0;
    logic          host_ack_cna = 1'b0;
    logic          host_reset = 1'b0;
    logic [AW-1:0] list_head = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic [1:0]    cu_state;
    logic          flag_cx, flag_cna, irq;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [0:63];
    logic [31:0] orig [0:63];
    int          rd_log [0:15];
    int          rd_n = 0;
    logic        req_q = 1'b0;
    logic [31:0] rdq = '0;

    cmd_list_unit #(.AW(AW), .EXEC_CYCLES(EXC)) u_cmd_list_unit (
        .clk(clk), .rst_n(rst_n), .ca(ca), .host_cmd(host_cmd),
        .host_ack_cx(host_ack_cx), .host_ack_cna(host_ack_cna),
        .host_reset(host_reset), .list_head(list_head),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cu_state(cu_state), .flag_cx(flag_cx), .flag_cna(flag_cna), .irq(irq)
    );

    always #5 clk = ~clk;

    // memory model: one-cycle response to every request
    always @(negedge clk) begin
        mem_rvalid = req_q;
        mem_rdata  = rdq;
        req_q      = mem_req;
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[5:0]] = mem_wdata;
            end else begin
                rdq = mem[mem_addr[5:0]];
                if (mem_addr[2:0] == 3'd0 && rd_n < 16) begin
                    rd_log[rd_n] = int'(mem_addr[5:0]);
                    rd_n = rd_n + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host(input logic [2:0] c, input logic ax, input logic an, input logic rs);
        ca = 1'b1; host_cmd = c; host_ack_cx = ax; host_ack_cna = an; host_reset = rs;
        @(negedge clk);
        ca = 1'b0; host_cmd = 3'd0; host_ack_cx = 1'b0; host_ack_cna = 1'b0; host_reset = 1'b0;
    endtask

    task automatic wait_state(input logic [1:0] s);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (cu_state == s) return;
        end
        chk("wait_state timeout", {30'd0, cu_state}, {30'd0, s});
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            mem[i] = 32'h0; orig[i] = 32'h0;
        end
    endtask

    // block k at word 8k, link to 8(k+1); el/s/i flags per block
    task automatic put_block(input int k, input bit el, input bit s, input bit i);
        mem[8*k]     = {el, s, i, 10'd0, 3'(k), 16'h0000};
        mem[8*k + 1] = 32'(8*(k+1));
        orig[8*k]    = mem[8*k];
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 state", {30'd0, cu_state}, 32'd0);
        chk("R1 req/flags/irq", {28'd0, mem_req, flag_cx, flag_cna, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {26'd0, cu_state, mem_req, flag_cx, flag_cna, irq}, 32'd0);

        // sweep: list lengths 1..3, every interrupt-bit pattern
        for (int n = 1; n <= 3; n++) begin
            for (int m = 0; m < (1 << n); m++) begin
                clear_mem();
                for (int k = 0; k < n; k++) put_block(k, k == n-1, 1'b0, m[k]);
                list_head = '0;
                rd_n = 0;
                host(3'd1, 1'b0, 1'b0, 1'b0);
                chk("R2 active after start", {30'd0, cu_state}, 32'd2);
                wait_state(2'd0);
                chk("R4 cna after end of list", {31'd0, flag_cna}, 32'd1);
                chk("R6 cx from interrupt bits", {31'd0, flag_cx}, {31'd0, m != 0});
                chk("R10 irq lags flags", {31'd0, irq},
                    {31'd0, (m & ((1 << (n-1)) - 1)) != 0});
                for (int k = 0; k < n; k++)
                    chk("R3 write-back", mem[8*k], orig[8*k] | 32'h0000A000);
                chk("R2 first read at head", 32'(rd_log[0]), 32'd0);
                chk("R3 blocks read", 32'(rd_n), 32'(n));
                @(negedge clk);
                chk("R10 irq one cycle later", {31'd0, irq}, 32'd1);
                host(3'd0, 1'b1, 1'b1, 1'b0);
                chk("R9 acks clear flags", {30'd0, flag_cx, flag_cna}, 32'd0);
                @(negedge clk);
                chk("R10 irq drops", {31'd0, irq}, 32'd0);
            end
        end

        // R5 suspend via block bit, then resume
        clear_mem();
        put_block(0, 1'b0, 1'b1, 1'b0);
        put_block(1, 1'b1, 1'b0, 1'b0);
        host(3'd1, 1'b0, 1'b0, 1'b0);
        wait_state(2'd1);
        chk("R5 suspended", {30'd0, cu_state}, 32'd1);
        chk("R5 cna on park", {31'd0, flag_cna}, 32'd1);
        chk("R5 block0 done", mem[0], orig[0] | 32'h0000A000);
        chk("R5 block1 untouched", mem[8], orig[8]);
        host(3'd0, 1'b0, 1'b1, 1'b0);
        rd_n = 0;
        host(3'd2, 1'b0, 1'b0, 1'b0);
        wait_state(2'd0);
        chk("R5 resume at link", 32'(rd_log[0]), 32'd8);
        chk("R5 block1 done", mem[8], orig[8] | 32'h0000A000);
        host(3'd0, 1'b1, 1'b1, 1'b0);

        // R5 host suspend command
        clear_mem();
        put_block(0, 1'b0, 1'b0, 1'b0);
        put_block(1, 1'b1, 1'b0, 1'b0);
        host(3'd1, 1'b0, 1'b0, 1'b0);
        host(3'd3, 1'b0, 1'b0, 1'b0);
        wait_state(2'd1);
        chk("R5 host suspend block1 untouched", mem[8], orig[8]);
        host(3'd2, 1'b0, 1'b0, 1'b0);
        wait_state(2'd0);
        chk("R5 host suspend then resume", mem[8], orig[8] | 32'h0000A000);
        host(3'd0, 1'b1, 1'b1, 1'b0);

        // R7 abort while suspended
        clear_mem();
        put_block(0, 1'b0, 1'b1, 1'b0);
        put_block(1, 1'b1, 1'b0, 1'b0);
        host(3'd1, 1'b0, 1'b0, 1'b0);
        wait_state(2'd1);
        host(3'd4, 1'b0, 1'b0, 1'b0);
        chk("R7 suspended abort to idle", {30'd0, cu_state}, 32'd0);
        repeat (40) @(negedge clk);
        chk("R7 suspended abort no write", mem[8], orig[8]);
        chk("R7 no request after", {31'd0, mem_req}, 32'd0);
        host(3'd0, 1'b1, 1'b1, 1'b0);

        // R7 abort while executing
        clear_mem();
        put_block(0, 1'b1, 1'b0, 1'b1);
        host(3'd1, 1'b0, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        host(3'd4, 1'b0, 1'b0, 1'b0);
        wait_state(2'd0);
        chk("R7 aborted status", mem[0], orig[0] | 32'h00009000);
        chk("R7 cna on abort", {31'd0, flag_cna}, 32'd1);
        chk("R6 abort sets no cx", {31'd0, flag_cx}, 32'd0);
        host(3'd0, 1'b1, 1'b1, 1'b0);

        // R8 start while active ignored
        clear_mem();
        put_block(0, 1'b0, 1'b0, 1'b0);
        put_block(1, 1'b1, 1'b0, 1'b0);
        put_block(5, 1'b1, 1'b0, 1'b0);
        rd_n = 0;
        host(3'd1, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        list_head = AW'(40);
        host(3'd1, 1'b0, 1'b0, 1'b0);
        wait_state(2'd0);
        chk("R8 reads in list order", {16'(rd_log[0]), 16'(rd_log[1])}, {16'd0, 16'd8});
        chk("R8 read count", 32'(rd_n), 32'd2);
        chk("R8 new head untouched", mem[40], orig[40]);
        chk("R8 list completed", mem[8], orig[8] | 32'h0000A000);
        list_head = '0;

        // R12 inert commands while idle (cna left set)
        host(3'd5, 1'b0, 1'b0, 1'b0);
        host(3'd6, 1'b0, 1'b0, 1'b0);
        host(3'd7, 1'b0, 1'b0, 1'b0);
        host(3'd0, 1'b0, 1'b0, 1'b0);
        chk("R12 idle unchanged", {29'd0, cu_state, flag_cna}, 32'd1);
        host(3'd0, 1'b1, 1'b1, 1'b0);

        // R12 inert commands while active
        clear_mem();
        put_block(0, 1'b0, 1'b0, 1'b0);
        put_block(1, 1'b1, 1'b0, 1'b0);
        host(3'd1, 1'b0, 1'b0, 1'b0);
        host(3'd5, 1'b0, 1'b0, 1'b0);
        host(3'd6, 1'b0, 1'b0, 1'b0);
        host(3'd7, 1'b0, 1'b0, 1'b0);
        chk("R12 active unchanged", {29'd0, cu_state, flag_cna}, 32'd4);
        wait_state(2'd0);
        chk("R12 list still completes", mem[8], orig[8] | 32'h0000A000);

        // R11 soft reset mid-run (cna still set, start command ignored)
        clear_mem();
        put_block(0, 1'b1, 1'b0, 1'b1);
        host(3'd1, 1'b0, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        host(3'd1, 1'b0, 1'b0, 1'b1);
        chk("R11 idle and flags clear", {29'd0, cu_state, flag_cx, flag_cna}, 32'd0);
        @(negedge clk);
        chk("R11 irq follows", {31'd0, irq}, 32'd0);
        repeat (40) @(negedge clk);
        chk("R11 no status written", mem[0], orig[0]);
        chk("R11 stays idle", {30'd0, cu_state}, 32'd0);

        // R9 acknowledge in the completion cycle: set wins
        clear_mem();
        put_block(0, 1'b1, 1'b0, 1'b1);
        host(3'd1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mem_req && mem_we) break;
        end
        @(negedge clk);
        host(3'd0, 1'b1, 1'b1, 1'b0);
        chk("R9 set wins over ack", {29'd0, cu_state, flag_cx, flag_cna}, 32'd3);
        host(3'd0, 1'b1, 1'b1, 1'b0);
        chk("R9 later ack clears", {30'd0, flag_cx, flag_cna}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule